// File: doc/BRIEF.md
# Floating-Point Partial Remainder Unit

This block performs one reduction step of a floating-point partial remainder. The dividend and the divisor enter as unpacked normal values. Each value has an unbiased exponent and a 64-bit mantissa whose leading one is explicit. The dividend also carries a sign. The divisor's sign has no effect on the result, so no divisor sign is brought in.

When the exponent gap is small enough, the block removes every whole multiple of the divisor. When the gap is large, it removes only a bounded slice of the quotient and raises a "not finished" condition bit. Software then issues the operation again until that bit reads zero. The low three quotient bits are reported on separate condition bits, so that software can recover an angle octant.

The unit is sequential. A one-cycle `start_i` pulse captures the operands. A restoring compare-subtract loop then produces one quotient bit per clock. The remainder is normalized, and a one-cycle `done_o` pulse presents the result. Results and condition bits hold their values until the next completion.

Top module: `fprem_unit`

## Requirements
- R1: With gap d = dividend exponent − divisor exponent in 0..63, the result equals dividend − q·divisor, where q is the magnitude ratio truncated toward zero. The result is exact. A nonzero result has mantissa bit 63 set, and its exponent is chosen so that the value is mantissa·2^(exp−63).
- R2: On that full path, `cc_o[2]` (C2) is 0, and the quotient's low bits are scattered as follows: q bit 0 → `cc_o[1]` (C1), q bit 1 → `cc_o[3]` (C3), q bit 2 → `cc_o[0]` (C0).
- R3: With d ≥ 64, the divisor is scaled by 2^(d−42), and the truncated whole multiple of the scaled divisor is removed from the dividend. C2 (`cc_o[2]`) is set to 1.
- R4: On that partial path, C0, C1 and C3 keep the values they held before the operation (0 after reset).
- R5: With d < 0, the dividend's exponent and mantissa are returned unchanged, and all four bits of `cc_o` are cleared.
- R6: The result sign is always the dividend's sign. A zero remainder is flagged with `r_zero_o`=1, `r_man_o`=0 and `r_exp_o`=0, and it keeps the dividend's sign.
- R7: `done_o` is a one-cycle pulse. Counting from the clock edge that samples `start_i`, it rises at edge d+2 on the full path, edge 44 on the partial path, and edge 1 when d < 0.
- R8: All result outputs and `cc_o` change only on the cycle where `done_o` is high. A `start_i` pulse that arrives while an operation is in flight is ignored.
- R9: After reset, `done_o`, `cc_o`, `r_man_o`, `r_exp_o`, `r_sign_o` and `r_zero_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request; operands are sampled on it when the unit is idle |
| dvd_sign_i | input | 1 | Dividend sign |
| dvd_exp_i | input | 16 | Dividend unbiased exponent, two's complement |
| dvd_man_i | input | 64 | Dividend mantissa, explicit leading one at bit 63 |
| dvs_exp_i | input | 16 | Divisor unbiased exponent, two's complement |
| dvs_man_i | input | 64 | Divisor mantissa, explicit leading one at bit 63 |
| done_o | output | 1 | One-cycle completion pulse |
| r_sign_o | output | 1 | Result sign |
| r_exp_o | output | 16 | Result unbiased exponent |
| r_man_o | output | 64 | Result mantissa, normalized unless zero |
| r_zero_o | output | 1 | Result is zero |
| cc_o | output | 4 | Condition bits, index n holds Cn |

## Verification
Each result is due a fixed number of edges after the edge that samples `start_i`: d+2 edges on the full path, 44 on the partial path, and 1 when the gap is negative. The driver computes this due edge from the exponent gap alone. It stores the edge with the expected remainder and condition bits in a scoreboard queue. The monitor counts clock edges and samples on falling edges. When `done_o` appears, it checks that the current edge number is the due edge, then compares the fields. On every idle falling edge in between, it confirms that no output has moved.

// File: rtl/fprem_pkg.sv
package fprem_pkg;

  // Widths of the unpacked operand format.
  localparam int unsigned PREM_MAN_W = 64;
  localparam int unsigned PREM_EXP_W = 16;
  // Exponent gap that a partial reduction leaves behind.
  localparam int unsigned PREM_PART_GAP = 42;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOP = 2'd1,
    ST_FIN  = 2'd2
  } prem_state_e;

endpackage

// File: rtl/fprem_ctrl.sv
module fprem_ctrl
  import fprem_pkg::*;
#(
  parameter int unsigned EXP_W    = PREM_EXP_W,
  parameter int unsigned MAN_W    = PREM_MAN_W,
  parameter int unsigned PART_GAP = PREM_PART_GAP,
  localparam int unsigned CNT_W   = $clog2(MAN_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [EXP_W-1:0] dvd_exp_i,
  input  logic [EXP_W-1:0] dvs_exp_i,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic             fin_o,
  output logic             neg_o,
  output logic             part_o,
  output logic [CNT_W-1:0] gap_o
);

  localparam logic signed [EXP_W:0] FULL_LIM = (EXP_W+1)'(MAN_W);

  prem_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] gap_q, gap_d;
  logic             neg_q, neg_d, part_q, part_d;

  logic signed [EXP_W:0] gap_raw;
  logic                  is_neg, is_part;
  logic                  accept;

  // Exponent gap classification
  always_comb begin
    gap_raw = $signed({dvd_exp_i[EXP_W-1], dvd_exp_i}) -
              $signed({dvs_exp_i[EXP_W-1], dvs_exp_i});
    is_neg  = gap_raw < 0;
    is_part = !is_neg && (gap_raw >= FULL_LIM);
  end

  assign accept = start_i && (state_q == ST_IDLE);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    gap_d   = gap_q;
    neg_d   = neg_q;
    part_d  = part_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          neg_d   = is_neg;
          part_d  = is_part;
          gap_d   = is_neg  ? '0 :
                    is_part ? CNT_W'(PART_GAP) : gap_raw[CNT_W-1:0];
          cnt_d   = gap_d;
          state_d = is_neg ? ST_FIN : ST_LOOP;
        end
      end
      ST_LOOP: begin
        if (cnt_q == '0) state_d = ST_FIN;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gap_q   <= '0;
      neg_q   <= 1'b0;
      part_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      gap_q   <= gap_d;
      neg_q   <= neg_d;
      part_q  <= part_d;
    end
  end

  assign load_o = accept;
  assign step_o = (state_q == ST_LOOP);
  assign last_o = (cnt_q == '0);
  assign fin_o  = (state_q == ST_FIN);
  assign neg_o  = neg_q;
  assign part_o = part_q;
  assign gap_o  = gap_q;

  // A request arriving mid-operation must not disturb the captured path.
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i) |=> ($stable(gap_q) && $stable(part_q) && $stable(neg_q)))
    else $error("busy start altered path");  // R8

  // The loop leaves through the finish state only.
  AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOOP && cnt_q == '0) |=> (state_q == ST_FIN))
    else $error("loop exit skipped finish");  // R7

endmodule

// File: rtl/fprem_divstep.sv
module fprem_divstep
  import fprem_pkg::*;
#(
  parameter int unsigned MAN_W = PREM_MAN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic [MAN_W-1:0] dvd_man_i,
  input  logic [MAN_W-1:0] dvs_man_i,
  output logic [MAN_W-1:0] rem_o,
  output logic [2:0]       qlo_o
);

  logic [MAN_W:0]   rem_q, rem_d;
  logic [MAN_W-1:0] div_q, div_d;
  logic [2:0]       qlo_q, qlo_d;

  logic [MAN_W:0] div_ext, diff, trial;
  logic           fits;

  // Restoring compare-subtract
  always_comb begin
    div_ext = {1'b0, div_q};
    fits    = rem_q >= div_ext;
    diff    = rem_q - div_ext;
    trial   = fits ? diff : rem_q;
  end

  always_comb begin
    rem_d = rem_q;
    div_d = div_q;
    qlo_d = qlo_q;
    if (load_i) begin
      rem_d = {1'b0, dvd_man_i};
      div_d = dvs_man_i;
      qlo_d = '0;
    end else if (step_i) begin
      rem_d = last_i ? trial : {trial[MAN_W-1:0], 1'b0};
      qlo_d = {qlo_q[1:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      div_q <= '0;
      qlo_q <= '0;
    end else if (load_i || step_i) begin
      rem_q <= rem_d;
      div_q <= div_d;
      qlo_q <= qlo_d;
    end
  end

  assign rem_o = rem_q[MAN_W-1:0];
  assign qlo_o = qlo_q;

  // Partial remainder stays below twice the divisor, so one bit per step suffices.
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (rem_q < {div_q, 1'b0}))
    else $error("partial remainder out of range");  // R1

  // After the final step the remainder is strictly below the divisor.
  AST_REM_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && last_i) |=> (rem_q < {1'b0, div_q}))
    else $error("final remainder not reduced");  // R1

endmodule

// File: rtl/fprem_norm.sv
module fprem_norm
  import fprem_pkg::*;
#(
  parameter int unsigned MAN_W  = PREM_MAN_W,
  localparam int unsigned CNT_W = $clog2(MAN_W)
) (
  input  logic [MAN_W-1:0] rem_i,
  output logic             zero_o,
  output logic [CNT_W-1:0] lead_o,
  output logic [MAN_W-1:0] man_o
);

  logic [CNT_W-1:0] lead;

  // Position of the most significant set bit
  always_comb begin
    lead = '0;
    for (int i = 0; i < MAN_W; i++) begin
      if (rem_i[i]) lead = CNT_W'(i);
    end
  end

  assign zero_o = (rem_i == '0);
  assign lead_o = lead;
  assign man_o  = rem_i << (CNT_W'(MAN_W - 1) - lead);

endmodule

// File: rtl/fprem_unit.sv
module fprem_unit
  import fprem_pkg::*;
#(
  parameter int unsigned EXP_W    = PREM_EXP_W,
  parameter int unsigned MAN_W    = PREM_MAN_W,
  parameter int unsigned PART_GAP = PREM_PART_GAP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dvd_sign_i,
  input  logic [EXP_W-1:0] dvd_exp_i,
  input  logic [MAN_W-1:0] dvd_man_i,
  input  logic [EXP_W-1:0] dvs_exp_i,
  input  logic [MAN_W-1:0] dvs_man_i,
  output logic             done_o,
  output logic             r_sign_o,
  output logic [EXP_W-1:0] r_exp_o,
  output logic [MAN_W-1:0] r_man_o,
  output logic             r_zero_o,
  output logic [3:0]       cc_o
);

  localparam int unsigned CNT_W = $clog2(MAN_W);
  localparam int unsigned XW    = EXP_W + 2;

  logic             load, step, last, fin, neg, part;
  logic [CNT_W-1:0] gap;
  logic [MAN_W-1:0] rem;
  logic [2:0]       qlo;
  logic             n_zero;
  logic [CNT_W-1:0] n_lead;
  logic [MAN_W-1:0] n_man;

  fprem_ctrl #(
    .EXP_W    (EXP_W),
    .MAN_W    (MAN_W),
    .PART_GAP (PART_GAP)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .dvd_exp_i (dvd_exp_i),
    .dvs_exp_i (dvs_exp_i),
    .load_o    (load),
    .step_o    (step),
    .last_o    (last),
    .fin_o     (fin),
    .neg_o     (neg),
    .part_o    (part),
    .gap_o     (gap)
  );

  fprem_divstep #(
    .MAN_W (MAN_W)
  ) u_divstep (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .step_i    (step),
    .last_i    (last),
    .dvd_man_i (dvd_man_i),
    .dvs_man_i (dvs_man_i),
    .rem_o     (rem),
    .qlo_o     (qlo)
  );

  fprem_norm #(
    .MAN_W (MAN_W)
  ) u_norm (
    .rem_i  (rem),
    .zero_o (n_zero),
    .lead_o (n_lead),
    .man_o  (n_man)
  );

  // Captured dividend sign and exponent
  logic             sign_q;
  logic [EXP_W-1:0] dexp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
      dexp_q <= '0;
    end else if (load) begin
      sign_q <= dvd_sign_i;
      dexp_q <= dvd_exp_i;
    end
  end

  // Result exponent: dividend exponent - gap - (MAN_W-1) + leading-one position
  logic signed [XW-1:0] exp_base, exp_calc;

  always_comb begin
    exp_base = XW'($signed(dexp_q));
    exp_calc = exp_base - $signed(XW'(gap)) + $signed(XW'(n_lead))
             - $signed(XW'(MAN_W - 1));
  end

  // Result next-state
  logic             sign_d, zero_d, done_d;
  logic [EXP_W-1:0] exp_d;
  logic [MAN_W-1:0] man_d;
  logic [3:0]       cc_d;

  always_comb begin
    sign_d = r_sign_o;
    zero_d = r_zero_o;
    exp_d  = r_exp_o;
    man_d  = r_man_o;
    cc_d   = cc_o;
    done_d = fin;
    if (fin) begin
      sign_d = sign_q;
      if (neg) begin
        zero_d = 1'b0;
        exp_d  = dexp_q;
        man_d  = rem;
        cc_d   = 4'b0000;
      end else begin
        zero_d = n_zero;
        exp_d  = n_zero ? '0 : exp_calc[EXP_W-1:0];
        man_d  = n_man;
        if (part) cc_d = {cc_o[3], 1'b1, cc_o[1], cc_o[0]};
        else      cc_d = {qlo[1], 1'b0, qlo[0], qlo[2]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      r_sign_o <= 1'b0;
      r_zero_o <= 1'b0;
      r_exp_o  <= '0;
      r_man_o  <= '0;
      cc_o     <= '0;
    end else begin
      done_o <= done_d;
      if (fin) begin
        r_sign_o <= sign_d;
        r_zero_o <= zero_d;
        r_exp_o  <= exp_d;
        r_man_o  <= man_d;
        cc_o     <= cc_d;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done longer than one cycle");  // R7

  AST_NORM_MAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !r_zero_o) |-> r_man_o[MAN_W-1])
    else $error("result not normalized");  // R1

  AST_ZERO_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && r_zero_o) |-> (r_man_o == '0 && r_exp_o == '0))
    else $error("zero result malformed");  // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(r_man_o) && $stable(r_exp_o) && $stable(cc_o) && $stable(r_sign_o)))
    else $error("outputs moved without done");  // R8

  AST_PART_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cc_o[2]) |-> ({cc_o[3], cc_o[1], cc_o[0]} == $past({cc_o[3], cc_o[1], cc_o[0]})))
    else $error("partial path changed quotient bits");  // R4

endmodule

// File: tb/fprem_unit_tb.sv
module fprem_unit_tb;

  localparam int EW = 16;
  localparam int MW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic          dvd_sign_i;
  logic [EW-1:0] dvd_exp_i;
  logic [MW-1:0] dvd_man_i;
  logic [EW-1:0] dvs_exp_i;
  logic [MW-1:0] dvs_man_i;
  logic          done_o;
  logic          r_sign_o;
  logic [EW-1:0] r_exp_o;
  logic [MW-1:0] r_man_o;
  logic          r_zero_o;
  logic [3:0]    cc_o;

  always #2.5 clk = ~clk;  // 200 MHz

  fprem_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dvd_sign_i (dvd_sign_i),
    .dvd_exp_i  (dvd_exp_i),
    .dvd_man_i  (dvd_man_i),
    .dvs_exp_i  (dvs_exp_i),
    .dvs_man_i  (dvs_man_i),
    .done_o     (done_o),
    .r_sign_o   (r_sign_o),
    .r_exp_o    (r_exp_o),
    .r_man_o    (r_man_o),
    .r_zero_o   (r_zero_o),
    .cc_o       (cc_o)
  );

  typedef struct {
    logic          sign;
    logic [EW-1:0] exp;
    logic [MW-1:0] man;
    logic          zero;
    logic [3:0]    cc;
    int            due;
    string         tv;
    string         tc;
  } exp_t;

  exp_t     sb_q[$];
  int       cyc = 0;
  int       n_chk = 0;
  int       n_fail = 0;
  logic [3:0] model_cc = 4'b0000;
  bit       finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [MW-1:0] act, input logic [MW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog expired: actual %0d expected below 150000", cyc);
      summary();
    end
  end

  // Monitor: compare on done, watch for movement in between
  logic          have_prev = 0;
  logic          moved = 0;
  logic          s_sign;
  logic [EW-1:0] s_exp;
  logic [MW-1:0] s_man;
  logic          s_zero;
  logic [3:0]    s_cc;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        if (have_prev)
          chk(!moved, "R8", "outputs moved between completions", {63'd0, moved}, 64'd0);
        moved = 0;
        if (sb_q.size() == 0) begin
          chk(0, "R7", "unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(cyc == e.due, "R7", "done edge", 64'(cyc), 64'(e.due));
          chk(r_sign_o == e.sign, "R6", "sign", {63'd0, r_sign_o}, {63'd0, e.sign});
          chk(r_zero_o == e.zero, "R6", "zero flag", {63'd0, r_zero_o}, {63'd0, e.zero});
          chk(r_man_o == e.man, e.tv, "mantissa", r_man_o, e.man);
          chk(r_exp_o == e.exp, e.tv, "exponent", {48'd0, r_exp_o}, {48'd0, e.exp});
          chk(cc_o == e.cc, e.tc, "condition bits", {60'd0, cc_o}, {60'd0, e.cc});
        end
        have_prev = 1;
        s_sign = r_sign_o; s_exp = r_exp_o; s_man = r_man_o;
        s_zero = r_zero_o; s_cc = cc_o;
      end else if (have_prev) begin
        if (r_sign_o != s_sign || r_exp_o != s_exp || r_man_o != s_man ||
            r_zero_o != s_zero || cc_o != s_cc)
          moved = 1;
      end
    end
  end

  // Driver: build expectation independently, apply stimulus, wait for result
  task automatic run_op(input logic sa, input int ea, input logic [MW-1:0] ma,
                        input int eb, input logic [MW-1:0] mb, input bit poke);
    exp_t e;
    int d, gap, lat, p;
    logic [127:0] num, q, r;
    logic [MW-1:0] rem;
    d = ea - eb;
    e.sign = sa;
    if (d < 0) begin
      e.man = ma; e.exp = EW'(ea); e.zero = 0; e.cc = 4'b0000;
      e.tv = "R5"; e.tc = "R5"; lat = 1;
    end else begin
      gap = (d >= 64) ? 42 : d;
      num = {64'd0, ma} << gap;
      q   = num / {64'd0, mb};
      r   = num % {64'd0, mb};
      rem = r[63:0];
      if (rem == 0) begin
        e.zero = 1; e.man = '0; e.exp = '0;
      end else begin
        p = 0;
        for (int i = 0; i < MW; i++) if (rem[i]) p = i;
        e.zero = 0;
        e.man  = rem << (63 - p);
        e.exp  = EW'(ea - gap - 63 + p);
      end
      if (d >= 64) begin
        e.cc = {model_cc[3], 1'b1, model_cc[1], model_cc[0]};
        e.tv = "R3"; e.tc = "R4";
      end else begin
        e.cc = {q[1], 1'b0, q[0], q[2]};
        e.tv = "R1"; e.tc = "R2";
      end
      lat = gap + 2;
    end
    model_cc = e.cc;
    @(negedge clk);
    e.due = cyc + 1 + lat;
    sb_q.push_back(e);
    dvd_sign_i = sa; dvd_exp_i = EW'(ea); dvd_man_i = ma;
    dvs_exp_i = EW'(eb); dvs_man_i = mb;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke && lat > 6) begin
      // R8: a request while busy must be ignored
      repeat (2) @(negedge clk);
      dvd_sign_i = ~sa; dvd_exp_i = EW'(ea + 5); dvd_man_i = ~ma | 64'h8000_0000_0000_0000;
      dvs_exp_i = EW'(eb - 3); dvs_man_i = 64'hFFFF_0000_0000_0001;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [MW-1:0] rnd_man();
    return {1'b1, $urandom(), $urandom()} [MW-1:0] | 64'h8000_0000_0000_0000;
  endfunction

  initial begin
    rst_n = 1'b0; start_i = 1'b0; dvd_sign_i = 1'b0;
    dvd_exp_i = '0; dvd_man_i = '0; dvs_exp_i = '0; dvs_man_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(done_o == 0 && cc_o == 0 && r_man_o == 0 && r_exp_o == 0 &&
        r_sign_o == 0 && r_zero_o == 0, "R9", "reset state",
        {44'd0, done_o, cc_o, r_exp_o, r_sign_o, r_zero_o}, 64'd0);

    // R1/R2: 10 rem 3 -> q=3, remainder 1
    run_op(0, 3, 64'hA000_0000_0000_0000, 1, 64'hC000_0000_0000_0000, 0);
    // R6: exact multiple, negative dividend -> signed zero
    run_op(1, 2, 64'hC000_0000_0000_0000, 1, 64'hC000_0000_0000_0000, 0);
    // R1: d=0 with dividend below divisor -> q=0
    run_op(0, 7, 64'h8000_0000_0000_0001, 7, 64'hF000_0000_0000_0000, 0);
    // R1: d=0 equal operands -> zero
    run_op(0, -4, 64'hD555_5555_5555_5555, -4, 64'hD555_5555_5555_5555, 0);
    // R2: q=5 -> C1=1 C3=0 C0=1 ; 11 rem 2 with scaling
    run_op(0, 3, 64'hB000_0000_0000_0000, 1, 64'h8000_0000_0000_0000, 0);
    // R1: d=63 boundary
    run_op(0, 70, rnd_man(), 7, rnd_man(), 1);
    // R3/R4: d=64 boundary, held bits from previous op
    run_op(1, 100, rnd_man(), 36, rnd_man(), 1);
    // R3/R4: large gap twice in a row
    run_op(0, 500, rnd_man(), 10, rnd_man(), 0);
    run_op(0, 300, rnd_man(), -200, rnd_man(), 1);
    // R5: negative gap clears all bits
    run_op(1, -5, rnd_man(), 9, rnd_man(), 0);
    run_op(0, 12, rnd_man(), 13, rnd_man(), 0);
    // R4: partial after cleared bits keeps zeros
    run_op(0, 90, rnd_man(), 0, rnd_man(), 0);
    // Random full path, mixed signs and gaps
    for (int k = 0; k < 30; k++) begin
      int g, eb;
      g  = int'($urandom_range(0, 63));
      eb = int'($urandom_range(0, 400)) - 200;
      run_op(logic'($urandom_range(0, 1)), eb + g, rnd_man(), eb, rnd_man(), (k % 4) == 0);
    end
    // Random partial path
    for (int k = 0; k < 6; k++) begin
      int g;
      g = int'($urandom_range(64, 900));
      run_op(logic'(k & 1), g - 100, rnd_man(), -100, rnd_man(), 1);
    end
    repeat (4) @(negedge clk);
    summary();
  end

endmodule